// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block turns an asynchronous serial line into parallel characters for a processor. It runs entirely from the receive clock. A two-bit rate field sets the bit time to 1, 16 or 64 receive-clock cycles. In the two oversampled rates, a falling edge on the line must still read low half a bit time later, or it is dropped as a false start. Every later bit is sampled one bit time after the previous sample, so each sample falls in the middle of its bit. Characters carry 5 to 8 data bits, least significant bit first, with an optional even or odd parity bit and one stop bit.

Each finished character is copied into a holding register and a ready flag is raised for the processor. A one-cycle read strobe clears the flag. A character is lost when the next one arrives before the read, or when the read lands in the same cycle as the copy. Either case sets a sticky overrun flag. Sticky parity and framing flags report bad characters, and an error-clear strobe clears all three sticky flags.

A separate monitor watches the line for a break: a low level lasting two whole frames. The break output stays high until the line samples high again.

Top module: `arx_top`

## Requirements
- R1: After reset, rx_rdy, rx_ovr, rx_pe, rx_fe and rx_brk are all 0, and rx_data is 0.
- R2: rxd is sampled on the rising edge of clk_rx. baud_sel=2'b10 gives a bit time of 16 clocks, 2'b11 gives 64 clocks, and 2'b00 or 2'b01 gives 1 clock. In the oversampled rates, the start bit is confirmed 8 or 32 clocks (half a bit) after the first low sample. Every data, parity and stop bit is then sampled one bit time after the previous sample.
- R3: char_len sets the number of data bits: 2'b00 gives 5 bits and 2'b11 gives 8 bits. Bits arrive least significant first. rx_data is right-aligned, and its unused upper bits are 0.
- R4: rx_rdy rises at the clock edge that samples the stop bit, at the same edge that rx_data is loaded. A one-cycle rd_stb clears rx_rdy, except when a new character is loaded in that same cycle.
- R5: When par_en=1, a parity bit follows the data bits. par_even=1 expects an even count of ones over the data and parity bits, and par_even=0 expects an odd count. A mismatch sets rx_pe.
- R6: In the oversampled rates, a low pulse shorter than half a bit time is ignored. No character is produced and no flag changes.
- R7: A stop bit sampled as 0 sets rx_fe. The character is still loaded into rx_data.
- R8: If a character is loaded while rx_rdy is still 1, rx_ovr is set and the earlier character is replaced.
- R9: If rd_stb is high in the same cycle that a character is loaded, rx_ovr is set.
- R10: rx_ovr, rx_pe and rx_fe stay set until err_clr is pulsed. If a new error occurs in the same cycle as err_clr, the flag stays set.
- R11: While rx_en=0 the receiver assembles nothing. Lowering rx_en part-way through a character discards that character.
- R12: rx_brk rises at the edge of the N-th consecutive low sample of rxd. N = 2 x (data bits + parity bit if enabled + 2) x the bit time in clocks. For example, 8 data bits with no parity at 16x gives N = 320. The break monitor works whatever the state of rx_en.
- R13: rx_brk stays high while rxd stays low. It clears at the first high sample of rxd, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock; rxd is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously inside the block |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial input line, idle high |
| rd_stb | input | 1 | Processor read strobe, one cycle wide |
| err_clr | input | 1 | Clears the sticky error flags |
| baud_sel | input | 2 | Bit-time select: 1x, 16x or 64x |
| char_len | input | 2 | Data bits per character, 5 to 8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| rx_data | output | DATA_W | Holding register, right-aligned |
| rx_rdy | output | 1 | A character is waiting to be read |
| rx_ovr | output | 1 | Overrun, sticky |
| rx_pe | output | 1 | Parity error, sticky |
| rx_fe | output | 1 | Framing error, sticky |
| rx_brk | output | 1 | Line break detected |

## Verification
The assertions check, on every cycle, the handover between the framer and the holding register. They cover the ready flag's set and clear, both overrun causes, the stickiness of the error flags and the silence of a disabled receiver. They also check that a break only rises after a low sample and always clears after a high one.

Only the bench's scenarios can show the bit timing. That covers mid-bit sampling at each rate, rejection of a false start, data alignment for each character length, parity polarity, and the exact sample count at which a break appears. These depend on values chosen in the stimulus, so no single-cycle property can express them.

// File: rtl/arx_pkg.sv
package arx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } arx_state_e;

  localparam logic [1:0] BAUD_MID  = 2'b10;
  localparam logic [1:0] BAUD_HIGH = 2'b11;

endpackage

// File: rtl/arx_framer.sv
module arx_framer
  import arx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rxd,
  input  logic              div_one,
  input  logic [CNT_W-1:0]  div_m1,
  input  logic [CNT_W-1:0]  half_m1,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              par_en,
  input  logic              par_even,
  output logic              xfer,
  output logic [DATA_W-1:0] xdata,
  output logic              xpe,
  output logic              xfe
);

  arx_state_e        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [LEN_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pb_q, pb_n;
  logic              tick;
  int                shamt;

  assign tick = (cnt_q == '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    sh_n  = sh_q;
    pb_n  = pb_q;
    xfer  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!rxd) begin
          if (div_one) begin
            st_n  = ST_DATA;
            cnt_n = div_m1;
            idx_n = '0;
          end else begin
            st_n  = ST_START;
            cnt_n = half_m1;
          end
        end
      end
      ST_START: begin
        if (tick) begin
          if (!rxd) begin
            st_n  = ST_DATA;
            cnt_n = div_m1;
            idx_n = '0;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_DATA: begin
        if (tick) begin
          sh_n  = {rxd, sh_q[DATA_W-1:1]};
          cnt_n = div_m1;
          if (idx_q == len_m1) begin
            st_n = par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_PAR: begin
        if (tick) begin
          pb_n  = rxd;
          st_n  = ST_STOP;
          cnt_n = div_m1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_STOP: begin
        if (tick) begin
          xfer = 1'b1;
          st_n = ST_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (!en) begin
      st_n = ST_IDLE;
      xfer = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      sh_q  <= sh_n;
      pb_q  <= pb_n;
    end
  end

  always_comb begin
    shamt = DATA_W - 1 - int'(len_m1);
    xdata = sh_q >> shamt;
    xpe   = par_en & ((^xdata) ^ pb_q ^ ~par_even);
    xfe   = ~rxd;
  end

endmodule

// File: rtl/arx_holdreg.sv
module arx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [DATA_W-1:0] xdata,
  input  logic              xpe,
  input  logic              xfe,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] dout,
  output logic              rdy,
  output logic              ovr,
  output logic              pe,
  output logic              fe
);

  logic rdy_n, ovr_n, pe_n, fe_n;
  logic ovr_hit;

  always_comb begin
    ovr_hit = xfer & (rdy | rd_stb);
    if (xfer)        rdy_n = 1'b1;
    else if (rd_stb) rdy_n = 1'b0;
    else             rdy_n = rdy;
    ovr_n = ovr_hit       | (ovr & ~err_clr);
    pe_n  = (xfer & xpe)  | (pe  & ~err_clr);
    fe_n  = (xfer & xfe)  | (fe  & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (xfer) begin
      dout <= xdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
    end else begin
      rdy <= rdy_n;
      ovr <= ovr_n;
      pe  <= pe_n;
      fe  <= fe_n;
    end
  end

endmodule

// File: rtl/arx_brkdet.sv
module arx_brkdet #(
  parameter int BRK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [BRK_W-1:0] thr_m1,
  output logic             brk
);

  logic [BRK_W-1:0] run_q, run_n;
  logic             brk_n;
  logic             full;

  always_comb begin
    full = (run_q >= thr_m1);
    if (rxd) begin
      run_n = '0;
      brk_n = 1'b0;
    end else begin
      run_n = full ? run_q : run_q + 1'b1;
      brk_n = full | brk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      brk   <= 1'b0;
    end else begin
      run_q <= run_n;
      brk   <= brk_n;
    end
  end

endmodule

// File: rtl/arx_top.sv
module arx_top
  import arx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic              clk_rx,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              rd_stb,
  input  logic              err_clr,
  input  logic [1:0]        baud_sel,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              rx_ovr,
  output logic              rx_pe,
  output logic              rx_fe,
  output logic              rx_brk
);

  localparam int CNT_W = $clog2(DIV_HIGH);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int BRK_W = $clog2(2 * (DATA_W + 3) * DIV_HIGH + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sn;
  int                div_sel;
  int                frame_bits;
  logic              div_one;
  logic [CNT_W-1:0]  div_m1;
  logic [CNT_W-1:0]  half_m1;
  logic [LEN_W-1:0]  len_m1;
  logic [BRK_W-1:0]  brk_thr_m1;
  logic              xfer;
  logic [DATA_W-1:0] xdata;
  logic              xpe;
  logic              xfe;

  always_ff @(posedge clk_rx or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_comb begin
    case (baud_sel)
      BAUD_MID:  div_sel = DIV_MID;
      BAUD_HIGH: div_sel = DIV_HIGH;
      default:   div_sel = 1;
    endcase
    div_one    = (div_sel == 1);
    div_m1     = CNT_W'(div_sel - 1);
    half_m1    = div_one ? '0 : CNT_W'(div_sel / 2 - 1);
    len_m1     = LEN_W'(4 + int'(char_len));
    frame_bits = int'(len_m1) + 3 + int'(par_en);
    brk_thr_m1 = BRK_W'(2 * frame_bits * div_sel - 1);
  end

  arx_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_framer (
    .clk      (clk_rx),
    .rst_n    (rst_sn),
    .en       (rx_en),
    .rxd      (rxd),
    .div_one  (div_one),
    .div_m1   (div_m1),
    .half_m1  (half_m1),
    .len_m1   (len_m1),
    .par_en   (par_en),
    .par_even (par_even),
    .xfer     (xfer),
    .xdata    (xdata),
    .xpe      (xpe),
    .xfe      (xfe)
  );

  arx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk_rx),
    .rst_n   (rst_sn),
    .xfer    (xfer),
    .xdata   (xdata),
    .xpe     (xpe),
    .xfe     (xfe),
    .rd_stb  (rd_stb),
    .err_clr (err_clr),
    .dout    (rx_data),
    .rdy     (rx_rdy),
    .ovr     (rx_ovr),
    .pe      (rx_pe),
    .fe      (rx_fe)
  );

  arx_brkdet #(.BRK_W(BRK_W)) u_brk (
    .clk    (clk_rx),
    .rst_n  (rst_sn),
    .rxd    (rxd),
    .thr_m1 (brk_thr_m1),
    .brk    (rx_brk)
  );

endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic clk,
  input logic rst_sn,
  input logic rxd,
  input logic rx_en,
  input logic rd_stb,
  input logic err_clr,
  input logic xfer,
  input logic rdy,
  input logic ovr,
  input logic pe,
  input logic fe,
  input logic brk
);

  a_r4_rdy_set: assert property (@(posedge clk) disable iff (!rst_sn)
    xfer |=> rdy);

  a_r4_rdy_clear: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_stb && !xfer) |=> !rdy);

  a_r8_unread_overrun: assert property (@(posedge clk) disable iff (!rst_sn)
    (xfer && rdy) |=> ovr);

  a_r9_collide_overrun: assert property (@(posedge clk) disable iff (!rst_sn)
    (xfer && rd_stb) |=> ovr);

  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    ((ovr || pe || fe) && !err_clr) |=> (ovr || pe || fe));

  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_sn)
    !rx_en |-> !xfer);

  a_r12_brk_after_low: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(brk) |-> $past(!rxd));

  a_r13_brk_clear: assert property (@(posedge clk) disable iff (!rst_sn)
    rxd |=> !brk);

endmodule

bind arx_top arx_checker u_arx_checker (
  .clk     (clk_rx),
  .rst_sn  (rst_sn),
  .rxd     (rxd),
  .rx_en   (rx_en),
  .rd_stb  (rd_stb),
  .err_clr (err_clr),
  .xfer    (xfer),
  .rdy     (rx_rdy),
  .ovr     (rx_ovr),
  .pe      (rx_pe),
  .fe      (rx_fe),
  .brk     (rx_brk)
);

// File: tb/arx_top_bench.sv
module arx_top_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk_rx;
  logic       rst_n;
  logic       rx_en;
  logic       rxd;
  logic       rd_stb;
  logic       err_clr;
  logic [1:0] baud_sel;
  logic [1:0] char_len;
  logic       par_en;
  logic       par_even;
  logic [7:0] rx_data;
  logic       rx_rdy;
  logic       rx_ovr;
  logic       rx_pe;
  logic       rx_fe;
  logic       rx_brk;

  int checks;
  int errors;
  int div;
  bit finished;

  arx_top u_arx_top (
    .clk_rx   (clk_rx),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rxd      (rxd),
    .rd_stb   (rd_stb),
    .err_clr  (err_clr),
    .baud_sel (baud_sel),
    .char_len (char_len),
    .par_en   (par_en),
    .par_even (par_even),
    .rx_data  (rx_data),
    .rx_rdy   (rx_rdy),
    .rx_ovr   (rx_ovr),
    .rx_pe    (rx_pe),
    .rx_fe    (rx_fe),
    .rx_brk   (rx_brk)
  );

  initial clk_rx = 1'b0;
  always #(CLK_PERIOD / 2) clk_rx = ~clk_rx;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] bs, input logic [1:0] cl,
                          input logic pen, input logic pev);
    baud_sel = bs;
    char_len = cl;
    par_en   = pen;
    par_even = pev;
    div = (bs == 2'b10) ? 16 : (bs == 2'b11) ? 64 : 1;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    rx_en   = 1'b1;
    rxd     = 1'b1;
    rd_stb  = 1'b0;
    err_clr = 1'b0;
    repeat (3) @(negedge clk_rx);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_rx);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (div) @(negedge clk_rx);
  endtask

  task automatic pulse_rd();
    rd_stb = 1'b1;
    @(negedge clk_rx);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk_rx);
    err_clr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par,
                      input logic stop_v, input bit collide);
    int nb;
    logic p;
    nb = 5 + int'(char_len);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (par_en) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (!par_even) p = ~p;
      if (bad_par) p = ~p;
      hold_bit(p);
    end
    for (int k = 0; k < div; k++) begin
      rxd    = stop_v;
      rd_stb = collide && (k == div / 2);
      @(negedge clk_rx);
    end
    rd_stb = 1'b0;
    rxd    = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rdy", int'(rx_rdy), 0);
    check("R1 ovr", int'(rx_ovr), 0);
    check("R1 pe", int'(rx_pe), 0);
    check("R1 fe", int'(rx_fe), 0);
    check("R1 brk", int'(rx_brk), 0);
    check("R1 data", int'(rx_data), 0);
  endtask

  task automatic t_basic_16x();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    send(8'hA5, 0, 1'b1, 0);
    check("R2 16x data", int'(rx_data), 'hA5);
    check("R4 rdy set", int'(rx_rdy), 1);
    check("R7 no fe", int'(rx_fe), 0);
    pulse_rd();
    check("R4 rdy clear", int'(rx_rdy), 0);
  endtask

  task automatic t_1x_even();
    do_reset();
    set_mode(2'b01, 2'b10, 1'b1, 1'b1);
    send(8'h35, 0, 1'b1, 0);
    check("R3 7-bit data", int'(rx_data), 'h35);
    check("R5 even ok", int'(rx_pe), 0);
    check("R2 1x rdy", int'(rx_rdy), 1);
    pulse_rd();
    send(8'hFF, 0, 1'b1, 0);
    check("R3 upper bits zero", int'(rx_data), 'h7F);
  endtask

  task automatic t_64x_odd_bad();
    do_reset();
    set_mode(2'b11, 2'b00, 1'b1, 1'b0);
    send(8'h16, 0, 1'b1, 0);
    check("R3 5-bit data", int'(rx_data), 'h16);
    check("R5 odd ok", int'(rx_pe), 0);
    pulse_rd();
    send(8'h0B, 1, 1'b1, 0);
    check("R5 odd bad", int'(rx_pe), 1);
    repeat (5) @(negedge clk_rx);
    check("R10 pe sticky", int'(rx_pe), 1);
    pulse_clr();
    check("R10 pe cleared", int'(rx_pe), 0);
  endtask

  task automatic t_framing();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    send(8'h5A, 0, 1'b0, 0);
    repeat (40) @(negedge clk_rx);
    check("R7 fe set", int'(rx_fe), 1);
    check("R7 data kept", int'(rx_data), 'h5A);
    pulse_clr();
    check("R10 fe cleared", int'(rx_fe), 0);
  endtask

  task automatic t_false_start();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (5) @(negedge clk_rx);
    rxd = 1'b1;
    repeat (60) @(negedge clk_rx);
    check("R6 no char", int'(rx_rdy), 0);
    check("R6 no fe", int'(rx_fe), 0);
    send(8'h3C, 0, 1'b1, 0);
    check("R6 recover", int'(rx_data), 'h3C);
  endtask

  task automatic t_overrun_unread();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    send(8'h11, 0, 1'b1, 0);
    check("R8 no ovr yet", int'(rx_ovr), 0);
    send(8'h22, 0, 1'b1, 0);
    check("R8 ovr set", int'(rx_ovr), 1);
    check("R8 data replaced", int'(rx_data), 'h22);
    pulse_clr();
    check("R10 ovr cleared", int'(rx_ovr), 0);
  endtask

  task automatic t_overrun_collide();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    send(8'h44, 0, 1'b1, 0);
    pulse_rd();
    check("R9 rdy low before", int'(rx_rdy), 0);
    send(8'h66, 0, 1'b1, 1);
    check("R9 ovr on collide", int'(rx_ovr), 1);
    check("R9 rdy kept", int'(rx_rdy), 1);
    check("R9 data new", int'(rx_data), 'h66);
  endtask

  task automatic t_disable();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    rx_en = 1'b0;
    send(8'h81, 0, 1'b1, 0);
    check("R11 no char when off", int'(rx_rdy), 0);
    rx_en = 1'b1;
    hold_bit(1'b0);
    hold_bit(1'b1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk_rx);
    rx_en = 1'b1;
    repeat (200) @(negedge clk_rx);
    check("R11 abandoned", int'(rx_rdy), 0);
    send(8'h42, 0, 1'b1, 0);
    check("R11 on again", int'(rx_data), 'h42);
  endtask

  task automatic t_break();
    do_reset();
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    rx_en = 1'b0;
    rxd = 1'b0;
    repeat (319) @(negedge clk_rx);
    check("R12 not yet", int'(rx_brk), 0);
    @(negedge clk_rx);
    check("R12 brk set", int'(rx_brk), 1);
    repeat (50) @(negedge clk_rx);
    check("R13 brk held", int'(rx_brk), 1);
    rxd = 1'b1;
    @(negedge clk_rx);
    check("R13 brk cleared", int'(rx_brk), 0);
  endtask

  initial begin
    finished = 1'b0;
    checks = 0;
    errors = 0;
    set_mode(2'b10, 2'b11, 1'b0, 1'b0);
    t_reset();
    t_basic_16x();
    t_1x_even();
    t_64x_odd_bad();
    t_framing();
    t_false_start();
    t_overrun_unread();
    t_overrun_collide();
    t_disable();
    t_break();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_rx);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule